// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block drives the control strobes and address pins of the external memory bus for an 8-bit microcontroller core. It runs on the oscillator clock and counts it off into machine cycles of twelve clocks. A cycle is six states, and each state has two phases. Within each cycle it produces the address-latch pulse, the active-low code-read strobe, the multiplexed low address/data byte and the high address byte. What it produces depends on the kind of access the core has asked for in that cycle.

The core presents a request at the end of every machine cycle. The request names one of five cycle kinds: internal code fetch, external code fetch, table read from code memory, data access with a 16-bit pointer, or data access with an 8-bit pointer. It also carries the addresses and write data. A control register bit lets software silence the free-running latch pulse to reduce emissions. Accesses that actually use the external bus still get their pulses. The bit is overridden whenever the external-execution strap is set.

Top module: `ext_bus_seq`

## Requirements
- R1: After a synchronous reset, the tick counter is at 0, the current cycle kind is internal fetch, and the disable bit is clear. The outputs are then ale=0, ale_oe=1, psen_n=1, ad_oe=0 and a_hi=0.
- R2: A machine cycle lasts 12 clocks, numbered tick 0 to 11. The request inputs, the strap and the disable bit are sampled only on the clock edge that ends tick 11, and they govern the whole next cycle. Values presented at any other tick have no effect.
- R3: Without suppression, ale is high for exactly one clock at tick 1 and for one clock at tick 7, which gives two pulses per cycle (one sixth of the clock rate).
- R4: In a data cycle (req_kind 3 = 16-bit pointer, 4 = 8-bit pointer), the tick-1 pulse is omitted and the tick-7 pulse remains, so there is one pulse per cycle.
- R5: psen_n is low at ticks 2–5 and 8–11 of an external code cycle (req_kind 1 = fetch, 2 = table read). It stays high through every cycle of kind 0 (internal fetch) and through every data cycle.
- R6: A write with ctrl_we=1 and ctrl_addr=8'h8E loads ctrl_wbit into the disable bit. The new value applies from the next machine-cycle boundary, and this includes a write made during tick 11. In an internal-fetch cycle with the bit set and strap_ext=0, ale_oe=0 and ale=1 (weak high) for all 12 ticks.
- R7: With the bit set and strap_ext=0, cycles of kind 1–4 still drive ale (ale_oe=1) with the pulse pattern of R3 and R4.
- R8: When strap_ext=1 is latched for a cycle, the disable bit has no effect: ale_oe=1 and the pulse pattern of R3 and R4 applies.
- R9: A write with any ctrl_addr other than 8'h8E leaves the disable bit unchanged.
- R10: In a code cycle, ad_out carries code_addr[7:0] with ad_oe=1 at ticks 0–1. It carries (code_addr+1)[7:0] with ad_oe=1 at ticks 6–7. At all other ticks ad_oe=0.
- R11: In a data cycle, ad_out carries the low address at ticks 6–7 with ad_oe=1: dptr[7:0] for kind 3, ri_addr for kind 4. At ticks 8–11, ad_out carries wdata with ad_oe=1 when req_write=1, and ad_oe=0 when req_write=0. At ticks 0–5, ad_oe=0. In kind-0 cycles, ad_oe=0 throughout.
- R12: a_hi carries code_addr[15:8] at ticks 0–5 and (code_addr+1)[15:8] at ticks 6–11 of a code cycle. It carries dptr[15:8] through a kind-3 cycle, and p2_latch through kind-4 and kind-0 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| req_kind | input | 3 | Kind of the next cycle (0 internal fetch, 1 external fetch, 2 table read, 3 data 16-bit, 4 data 8-bit; others as 0) |
| req_write | input | 1 | Data cycle writes (1) or reads (0) |
| strap_ext | input | 1 | External-execution strap, 1 = code runs from external memory |
| code_addr | input | 16 | Code address of the next cycle |
| dptr | input | 16 | 16-bit data pointer |
| ri_addr | input | 8 | 8-bit data pointer |
| p2_latch | input | 8 | Port 2 output register contents |
| wdata | input | 8 | Write data for data cycles |
| ctrl_we | input | 1 | Special-register write strobe |
| ctrl_addr | input | 8 | Special-register write address |
| ctrl_wbit | input | 1 | Value written to the latch-pulse disable bit |
| ale | output | 1 | Address-latch pulse value |
| ale_oe | output | 1 | Strong drive of ale; 0 leaves only the weak pull-up |
| psen_n | output | 1 | Active-low code-read strobe |
| ad_out | output | 8 | Multiplexed low address / data byte |
| ad_oe | output | 1 | Drive enable for ad_out |
| a_hi | output | 8 | High address byte |

## Verification
A write to the disable bit and the sampling of the next request can fall on the same edge, the one that ends tick 11. The bench provokes this on purpose by raising ctrl_we exactly in tick 11, both while the next request is an internal fetch and while it is an external data access. The cycle that follows is then judged on two things: whether ale is floated or pulsed, and how many pulses it carries. The bench also changes requests at random on every tick, so that only the values present at tick 11 may show up in the outputs.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;

    typedef enum logic [2:0] {
        K_INT    = 3'd0,
        K_CODE   = 3'd1,
        K_MOVC   = 3'd2,
        K_XWIDE  = 3'd3,
        K_XNARW  = 3'd4
    } kind_e;

    typedef struct packed {
        kind_e               kind;
        logic                strap_ext;
        logic                ale_dis;
        logic                wr;
        logic [ADDR_W-1:0]   code_addr;
        logic [ADDR_W-1:0]   dptr;
        logic [BYTE_W-1:0]   ri_addr;
        logic [BYTE_W-1:0]   p2;
        logic [BYTE_W-1:0]   wdata;
    } cyc_t;

    function automatic kind_e decode_kind(input logic [2:0] raw);
        case (raw)
            3'd1:    return K_CODE;
            3'd2:    return K_MOVC;
            3'd3:    return K_XWIDE;
            3'd4:    return K_XNARW;
            default: return K_INT;
        endcase
    endfunction

    function automatic logic is_data(input kind_e k);
        return (k == K_XWIDE) || (k == K_XNARW);
    endfunction

    function automatic logic is_code(input kind_e k);
        return (k == K_CODE) || (k == K_MOVC);
    endfunction

endpackage

// File: rtl/ebs_timebase.sv
module ebs_timebase #(
    parameter int CPS = 2,
    parameter int NST = 6,
    parameter int TW  = $clog2(CPS * NST)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [TW-1:0] tick,
    output logic          cyc_last
);
    localparam logic [TW-1:0] LAST = TW'(CPS * NST - 1);

    assign cyc_last = (tick == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            tick <= '0;
        else if (cyc_last)
            tick <= '0;
        else
            tick <= tick + 1'b1;
    end
endmodule

// File: rtl/ebs_cycle_reg.sv
module ebs_cycle_reg
    import ebs_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CTRL_ADDR = 8'h8E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_last,
    input  logic [2:0]        req_kind,
    input  logic              req_write,
    input  logic              strap_ext,
    input  logic [ADDR_W-1:0] code_addr,
    input  logic [ADDR_W-1:0] dptr,
    input  logic [BYTE_W-1:0] ri_addr,
    input  logic [BYTE_W-1:0] p2_latch,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ctrl_we,
    input  logic [BYTE_W-1:0] ctrl_addr,
    input  logic              ctrl_wbit,
    output cyc_t              cur
);
    logic dis_q;
    logic hit;
    logic dis_nxt;
    cyc_t nxt;

    assign hit     = ctrl_we && (ctrl_addr == CTRL_ADDR);
    assign dis_nxt = hit ? ctrl_wbit : dis_q;

    always_comb begin
        nxt.kind      = decode_kind(req_kind);
        nxt.strap_ext = strap_ext;
        nxt.ale_dis   = dis_nxt;
        nxt.wr        = req_write;
        nxt.code_addr = code_addr;
        nxt.dptr      = dptr;
        nxt.ri_addr   = ri_addr;
        nxt.p2        = p2_latch;
        nxt.wdata     = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dis_q <= 1'b0;
            cur   <= '0;
        end else begin
            dis_q <= dis_nxt;
            if (cyc_last)
                cur <= nxt;
        end
    end
endmodule

// File: rtl/ebs_strobe_gen.sv
module ebs_strobe_gen
    import ebs_pkg::*;
#(
    parameter int CPS = 2,
    parameter int NST = 6,
    parameter int TW  = $clog2(CPS * NST)
) (
    input  logic [TW-1:0] tick,
    input  kind_e         kind,
    input  logic          strap_ext,
    input  logic          ale_dis,
    output logic          ale,
    output logic          ale_oe,
    output logic          psen_n
);
    localparam logic [TW-1:0] SLOT_A = TW'(CPS - 1);
    localparam logic [TW-1:0] SLOT_B = TW'(4 * CPS - 1);
    localparam logic [TW-1:0] RDA_LO = TW'(CPS);
    localparam logic [TW-1:0] RDA_HI = TW'(3 * CPS - 1);
    localparam logic [TW-1:0] RDB_LO = TW'(4 * CPS);
    localparam logic [TW-1:0] RDB_HI = TW'(NST * CPS - 1);

    logic suppress, ext_cyc, data_cyc, code_cyc;
    logic pulse_a, pulse_b, rd_win;

    assign suppress = ale_dis && !strap_ext;
    assign ext_cyc  = (kind != K_INT);
    assign data_cyc = is_data(kind);
    assign code_cyc = is_code(kind);

    assign pulse_a = (tick == SLOT_A) && !data_cyc && (code_cyc || !suppress);
    assign pulse_b = (tick == SLOT_B) && (ext_cyc || !suppress);

    assign rd_win = ((tick >= RDA_LO) && (tick <= RDA_HI)) ||
                    ((tick >= RDB_LO) && (tick <= RDB_HI));

    always_comb begin
        if (suppress && !ext_cyc) begin
            ale    = 1'b1;
            ale_oe = 1'b0;
        end else begin
            ale    = pulse_a || pulse_b;
            ale_oe = 1'b1;
        end
        psen_n = !(code_cyc && rd_win);
    end
endmodule

// File: rtl/ebs_bus_mux.sv
module ebs_bus_mux
    import ebs_pkg::*;
#(
    parameter int CPS = 2,
    parameter int NST = 6,
    parameter int TW  = $clog2(CPS * NST)
) (
    input  logic [TW-1:0]     tick,
    input  kind_e             kind,
    input  logic              wr,
    input  logic [ADDR_W-1:0] code_addr,
    input  logic [ADDR_W-1:0] dptr,
    input  logic [BYTE_W-1:0] ri_addr,
    input  logic [BYTE_W-1:0] p2,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [BYTE_W-1:0] a_hi
);
    localparam logic [TW-1:0] LATA_END = TW'(CPS);
    localparam logic [TW-1:0] LATB_LO  = TW'(3 * CPS);
    localparam logic [TW-1:0] LATB_HI  = TW'(4 * CPS - 1);
    localparam logic [TW-1:0] WR_LO    = TW'(4 * CPS);

    logic [ADDR_W-1:0] code_nxt;
    logic              in_lat_b;

    assign code_nxt = code_addr + 1'b1;
    assign in_lat_b = (tick >= LATB_LO) && (tick <= LATB_HI);

    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        a_hi   = p2;
        if (is_code(kind)) begin
            if (tick < LATA_END) begin
                ad_out = code_addr[BYTE_W-1:0];
                ad_oe  = 1'b1;
            end else if (in_lat_b) begin
                ad_out = code_nxt[BYTE_W-1:0];
                ad_oe  = 1'b1;
            end
            a_hi = (tick < LATB_LO) ? code_addr[ADDR_W-1:BYTE_W]
                                    : code_nxt[ADDR_W-1:BYTE_W];
        end else if (is_data(kind)) begin
            if (kind == K_XWIDE)
                a_hi = dptr[ADDR_W-1:BYTE_W];
            if (in_lat_b) begin
                ad_out = (kind == K_XWIDE) ? dptr[BYTE_W-1:0] : ri_addr;
                ad_oe  = 1'b1;
            end else if ((tick >= WR_LO) && wr) begin
                ad_out = wdata;
                ad_oe  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ebs_pkg::*;
#(
    parameter int                CLKS_PER_STATE = 2,
    parameter int                STATES         = 6,
    parameter logic [BYTE_W-1:0] CTRL_ADDR      = 8'h8E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        req_kind,
    input  logic              req_write,
    input  logic              strap_ext,
    input  logic [ADDR_W-1:0] code_addr,
    input  logic [ADDR_W-1:0] dptr,
    input  logic [BYTE_W-1:0] ri_addr,
    input  logic [BYTE_W-1:0] p2_latch,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ctrl_we,
    input  logic [BYTE_W-1:0] ctrl_addr,
    input  logic              ctrl_wbit,
    output logic              ale,
    output logic              ale_oe,
    output logic              psen_n,
    output logic [BYTE_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [BYTE_W-1:0] a_hi
);
    localparam int CYC_LEN = CLKS_PER_STATE * STATES;
    localparam int TW      = $clog2(CYC_LEN);

    logic [TW-1:0] tick;
    logic          cyc_last;
    cyc_t          cur;
    logic [2:0]    cur_kind_w;

    assign cur_kind_w = cur.kind;

    ebs_timebase #(.CPS(CLKS_PER_STATE), .NST(STATES), .TW(TW)) u_tb (
        .clk(clk), .rst(rst), .tick(tick), .cyc_last(cyc_last)
    );

    ebs_cycle_reg #(.CTRL_ADDR(CTRL_ADDR)) u_creg (
        .clk(clk), .rst(rst), .cyc_last(cyc_last),
        .req_kind(req_kind), .req_write(req_write), .strap_ext(strap_ext),
        .code_addr(code_addr), .dptr(dptr), .ri_addr(ri_addr),
        .p2_latch(p2_latch), .wdata(wdata),
        .ctrl_we(ctrl_we), .ctrl_addr(ctrl_addr), .ctrl_wbit(ctrl_wbit),
        .cur(cur)
    );

    ebs_strobe_gen #(.CPS(CLKS_PER_STATE), .NST(STATES), .TW(TW)) u_stb (
        .tick(tick), .kind(cur.kind), .strap_ext(cur.strap_ext),
        .ale_dis(cur.ale_dis), .ale(ale), .ale_oe(ale_oe), .psen_n(psen_n)
    );

    ebs_bus_mux #(.CPS(CLKS_PER_STATE), .NST(STATES), .TW(TW)) u_mux (
        .tick(tick), .kind(cur.kind), .wr(cur.wr), .code_addr(cur.code_addr),
        .dptr(cur.dptr), .ri_addr(cur.ri_addr), .p2(cur.p2), .wdata(cur.wdata),
        .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi)
    );
endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk #(
    parameter int TW     = 4,
    parameter int LAST   = 11,
    parameter int SLOT_A = 1
) (
    input logic          clk,
    input logic          rst,
    input logic [TW-1:0] tick,
    input logic [2:0]    cur_kind,
    input logic          cur_strap,
    input logic          ale,
    input logic          ale_oe,
    input logic          psen_n,
    input logic          ad_oe
);
    logic data_cyc;
    assign data_cyc = (cur_kind == 3'd3) || (cur_kind == 3'd4);

    AST_TICK_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick == TW'(LAST)) |=> (tick == '0)); // R2

    AST_ALE_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
        (ale && ale_oe) |=> !(ale && ale_oe)); // R3

    AST_NO_SLOT_A_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        (data_cyc && tick == TW'(SLOT_A)) |-> !(ale && ale_oe)); // R4

    AST_NO_PSEN_IN_DATA: assert property (@(posedge clk) disable iff (rst)
        (data_cyc || cur_kind == 3'd0) |-> psen_n); // R5

    AST_WEAK_HIGH: assert property (@(posedge clk) disable iff (rst)
        !ale_oe |-> ale); // R6

    AST_STRAP_DRIVES: assert property (@(posedge clk) disable iff (rst)
        cur_strap |-> ale_oe); // R8

    AST_BUS_FLOAT_ON_READ: assert property (@(posedge clk) disable iff (rst)
        !psen_n |-> !ad_oe); // R10
endmodule

bind ext_bus_seq ext_bus_seq_chk #(.TW(TW), .LAST(CYC_LEN - 1), .SLOT_A(CLKS_PER_STATE - 1)) i_chk (
    .clk(clk), .rst(rst), .tick(tick), .cur_kind(cur_kind_w),
    .cur_strap(cur.strap_ext), .ale(ale), .ale_oe(ale_oe),
    .psen_n(psen_n), .ad_oe(ad_oe)
);

// File: tb/test_ext_bus_seq.sv
`timescale 1ns/1ps
module test_ext_bus_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0]  req_kind = '0;
    logic        req_write = 1'b0, strap_ext = 1'b0;
    logic [15:0] code_addr = '0, dptr = '0;
    logic [7:0]  ri_addr = '0, p2_latch = '0, wdata = '0;
    logic        ctrl_we = 1'b0, ctrl_wbit = 1'b0;
    logic [7:0]  ctrl_addr = '0;
    logic        ale, ale_oe, psen_n, ad_oe;
    logic [7:0]  ad_out, a_hi;

    always #2.5 clk = ~clk;

    ext_bus_seq i_ext_bus_seq (
        .clk(clk), .rst(rst), .req_kind(req_kind), .req_write(req_write),
        .strap_ext(strap_ext), .code_addr(code_addr), .dptr(dptr),
        .ri_addr(ri_addr), .p2_latch(p2_latch), .wdata(wdata),
        .ctrl_we(ctrl_we), .ctrl_addr(ctrl_addr), .ctrl_wbit(ctrl_wbit),
        .ale(ale), .ale_oe(ale_oe), .psen_n(psen_n), .ad_out(ad_out),
        .ad_oe(ad_oe), .a_hi(a_hi)
    );

    int n_chk = 0, n_bad = 0;
    bit live = 0, done = 0;
    string scene = "reset";

    // behavioural reference state
    int m_t = 0, m_kind = 0, pulses = 0;
    bit m_dis = 0, c_dis = 0, c_strap = 0, c_wr = 0;
    logic [15:0] c_code = '0, c_dptr = '0;
    logic [7:0]  c_ri = '0, c_p2 = '0, c_wd = '0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s [%s] t=%0d act=%0h exp=%0h", tag, scene, m_t, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit nd;
        if (rst) begin
            m_t = 0; m_kind = 0; m_dis = 0; c_dis = 0; c_strap = 0; c_wr = 0;
            c_code = '0; c_dptr = '0; c_ri = '0; c_p2 = '0; c_wd = '0;
        end else begin
            nd = (ctrl_we && ctrl_addr == 8'h8E) ? ctrl_wbit : m_dis;
            if (m_t == 11) begin // R2: sample only at the end of tick 11
                m_kind = (req_kind <= 3'd4) ? int'(req_kind) : 0;
                c_dis = nd; c_strap = strap_ext; c_wr = req_write;
                c_code = code_addr; c_dptr = dptr; c_ri = ri_addr;
                c_p2 = p2_latch; c_wd = wdata;
            end
            m_dis = nd;
            m_t = (m_t == 11) ? 0 : m_t + 1;
        end
    end

    always @(negedge clk) begin
        bit ext, code, data, sup, e_ale, e_oe, e_psen, e_adoe;
        int e_ad, e_ahi, e_cnt;
        logic [15:0] nxt;
        string atag;
        if (live && !rst) begin
            ext = (m_kind != 0); code = (m_kind == 1 || m_kind == 2);
            data = (m_kind == 3 || m_kind == 4);
            sup = c_dis && !c_strap;
            if (sup && !ext) begin e_ale = 1; e_oe = 0; end
            else begin
                e_oe = 1;
                e_ale = (m_t == 1 && !data) || (m_t == 7);
            end
            if (c_strap && c_dis) atag = "R8";
            else if (sup && ext) atag = "R7";
            else if (sup) atag = "R6";
            else if (data) atag = "R4";
            else atag = "R3";
            chk({atag, " ale"}, ale, e_ale);
            chk({atag, " ale_oe"}, ale_oe, e_oe);
            e_psen = !(code && ((m_t >= 2 && m_t <= 5) || m_t >= 8));
            chk("R5 psen_n", psen_n, e_psen);
            nxt = c_code + 16'd1;
            e_ad = 0; e_adoe = 0; e_ahi = c_p2;
            if (code) begin
                if (m_t <= 1) begin e_ad = c_code[7:0]; e_adoe = 1; end
                if (m_t == 6 || m_t == 7) begin e_ad = nxt[7:0]; e_adoe = 1; end
                e_ahi = (m_t < 6) ? c_code[15:8] : nxt[15:8];
                chk("R10 ad_oe", ad_oe, e_adoe);
                if (e_adoe) chk("R10 ad_out", ad_out, e_ad);
            end else begin
                if (m_kind == 3) e_ahi = c_dptr[15:8];
                if (data && (m_t == 6 || m_t == 7)) begin
                    e_ad = (m_kind == 3) ? c_dptr[7:0] : c_ri; e_adoe = 1;
                end
                if (data && m_t >= 8 && c_wr) begin e_ad = c_wd; e_adoe = 1; end
                chk("R11 ad_oe", ad_oe, e_adoe);
                if (e_adoe) chk("R11 ad_out", ad_out, e_ad);
            end
            chk("R12 a_hi", a_hi, e_ahi);
            if (ale && ale_oe) pulses++;
            if (m_t == 11) begin
                e_cnt = (sup && !ext) ? 0 : (data ? 1 : 2);
                chk({atag, " pulses/cycle"}, pulses, e_cnt);
                pulses = 0;
            end
        end
    end

    task automatic set_req(int k, bit w, logic [15:0] ca, logic [15:0] dp,
                           logic [7:0] ri, logic [7:0] p2, logic [7:0] wd);
        req_kind = 3'(k); req_write = w; code_addr = ca; dptr = dp;
        ri_addr = ri; p2_latch = p2; wdata = wd;
    endtask

    task automatic cycles(int n);
        repeat (n * 12) @(negedge clk);
    endtask

    task automatic ctrl_write(logic [7:0] a, bit v);
        ctrl_addr = a; ctrl_wbit = v; ctrl_we = 1'b1;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic to_tick11;
        while (m_t != 11) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: state right after reset
        chk("R1 ale", ale, 0);
        chk("R1 ale_oe", ale_oe, 1);
        chk("R1 psen_n", psen_n, 1);
        chk("R1 ad_oe", ad_oe, 0);
        chk("R1 a_hi", a_hi, 0);
        rst = 1'b0; live = 1;

        scene = "R3 internal free run";
        set_req(0, 0, 16'h1234, 16'h0, 8'h0, 8'hA5, 8'h0);
        cycles(3);

        scene = "R5 R10 R12 external fetch";
        set_req(1, 0, 16'h12FF, 16'h0, 8'h0, 8'hA5, 8'h0);
        cycles(2);
        set_req(1, 0, 16'hFFFF, 16'h0, 8'h0, 8'h3C, 8'h0);
        cycles(2);
        set_req(2, 0, 16'h4080, 16'h0, 8'h0, 8'h3C, 8'h0);
        cycles(2);

        scene = "R4 R11 data cycles";
        set_req(3, 1, 16'h0, 16'hBEEF, 8'h11, 8'h22, 8'h5A);
        cycles(2);
        set_req(3, 0, 16'h0, 16'hC0DE, 8'h11, 8'h22, 8'h5A);
        cycles(2);
        set_req(4, 1, 16'h0, 16'hC0DE, 8'h77, 8'h99, 8'hE1);
        cycles(2);
        set_req(4, 0, 16'h0, 16'hC0DE, 8'h78, 8'h98, 8'hE1);
        cycles(2);

        scene = "R6 disabled internal";
        set_req(0, 0, 16'h0100, 16'h0, 8'h0, 8'h44, 8'h0);
        @(negedge clk); @(negedge clk);
        ctrl_write(8'h8E, 1);
        cycles(3);

        scene = "R7 disabled external";
        for (int k = 1; k <= 4; k++) begin
            set_req(k, k[0], 16'h2000 + 16'(k), 16'h9000, 8'h10, 8'h20, 8'h30);
            cycles(2);
        end

        scene = "R8 strap overrides";
        strap_ext = 1'b1;
        set_req(0, 0, 16'h0, 16'h0, 8'h0, 8'h55, 8'h0);
        cycles(2);
        set_req(3, 0, 16'h0, 16'h8421, 8'h0, 8'h55, 8'h0);
        cycles(2);
        strap_ext = 1'b0;

        scene = "R9 other addresses";
        set_req(0, 0, 16'h0, 16'h0, 8'h0, 8'h66, 8'h0);
        ctrl_write(8'h8E, 0);
        cycles(1);
        ctrl_write(8'h8F, 1);
        ctrl_write(8'h8D, 1);
        ctrl_write(8'h0E, 1);
        cycles(3);

        scene = "R6 write in tick 11";
        to_tick11();
        ctrl_write(8'h8E, 1);
        cycles(2);
        set_req(4, 1, 16'h0, 16'h0, 8'hAB, 8'hCD, 8'hEF);
        to_tick11();
        ctrl_write(8'h8E, 0);
        to_tick11();
        set_req(0, 0, 16'h0, 16'h0, 8'h0, 8'h12, 8'h0);
        cycles(2);

        scene = "R2 random per tick";
        for (int i = 0; i < 600; i++) begin
            set_req(int'($urandom_range(0, 7)), 1'($urandom), 16'($urandom),
                    16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
            strap_ext = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 19) == 0) begin
                ctrl_addr = ($urandom_range(0, 1) == 0) ? 8'h8E : 8'($urandom);
                ctrl_wbit = 1'($urandom); ctrl_we = 1'b1;
            end else ctrl_we = 1'b0;
            @(negedge clk);
        end
        ctrl_we = 1'b0;
        cycles(2);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule